// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block decides, once per clock, whether the core enters a handler. Candidates are a pending synchronous exception and an external interrupt offered by the interrupt controller. When an event is accepted, the block saves the machine state and forms the handler address in a single step. It saves the status word, the return address and stack register 15. It then raises the privileged, bank-select and block bits in the status word, records the cause code and loads the new program counter.

The core presents its current status word, program counter, register 15, vector base, delay-slot flags and the event inputs. All results are registered and commit together on one clock edge. That edge is marked by a one-cycle `taken_o` pulse. When no event is accepted, every registered output keeps its value.

The block also owns the sleep flag. The core sets it with `sleep_enter_i`, and the flag is cleared whenever an event is taken. While the block bit is set, the sleep flag is the only way an interrupt can get through.

Top module: `exc_entry_seq`

## Requirements
- R1: When `exc_valid_i` and an acceptable interrupt arrive in the same cycle, only the exception is taken: `expevt_o` is written and `intevt_o` keeps its value.
- R2: With the block bit (SR bit 28) set, any exception code other than 0x1E0 is recorded and vectored as code 0x000. Code 0x1E0 keeps its own code.
- R3: With SR bit 28 set, an interrupt is not taken unless `sleep_o` is 1. Taking any event clears `sleep_o`. `sleep_enter_i` sets it when no event is taken.
- R4: An interrupt is taken only when `irq_prio_i` is strictly greater than the mask in SR[7:4]. Otherwise `taken_o` stays 0 and all outputs hold.
- R5: On entry, `ssr_o` receives `sr_i` and `sgr_o` receives `r15_i`. `sr_o` is `sr_i` with bits 30, 29 and 28 set, plus the changes of R7.
- R6: When either bit of `dslot_i` is 1, `spc_o` is `pc_i - 2` and `dslot_clr_o` is 1. Otherwise `spc_o` is `pc_i` and `dslot_clr_o` is 0.
- R7: Codes 0x000, 0x020 and 0x140 clear SR bit 15, set SR[7:4] to 0xF and load PC 0xA0000000.
- R8: Codes 0x040 and 0x060 go to `vbr_i + 0x400`. Every other exception goes to `vbr_i + 0x100`. Code 0x160 also adds 2 to the saved PC.
- R9: An exception writes its code to `expevt_o`. An interrupt writes `irq_code_i` to `intevt_o` and loads `vbr_i + 0x600`.
- R10: Each accepted event gives `taken_o` = 1 for one cycle, and all outputs change in that same cycle. In a cycle with no accepted event, `taken_o` is 0 and all outputs hold.
- R11: While `rst_n` is low on a clock edge, the block resets as follows. PC becomes 0xA0000000 and SR becomes 0x70000000. `sleep_o`, `taken_o` and `dslot_clr_o` become 0, and all other outputs are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_valid_i | input | 1 | A synchronous exception is pending |
| exc_code_i | input | 12 | Code of the pending exception |
| irq_req_i | input | 1 | Interrupt controller has a pending source |
| irq_prio_i | input | 4 | Priority of that source |
| irq_code_i | input | 12 | Code of that source |
| sr_i | input | 32 | Current status word |
| pc_i | input | 32 | Address of the current instruction |
| r15_i | input | 32 | Current general register 15 |
| vbr_i | input | 32 | Vector base |
| dslot_i | input | 2 | Delay-slot flags (unconditional, conditional) |
| sleep_enter_i | input | 1 | Core enters sleep |
| sr_o | output | 32 | Status word after entry |
| ssr_o | output | 32 | Saved status word |
| spc_o | output | 32 | Saved return address |
| sgr_o | output | 32 | Saved register 15 |
| expevt_o | output | 12 | Last exception code |
| intevt_o | output | 12 | Last interrupt code |
| pc_o | output | 32 | Handler address |
| sleep_o | output | 1 | Sleep flag |
| dslot_clr_o | output | 1 | Delay-slot flags must be cleared |
| taken_o | output | 1 | One-cycle entry strobe |

## Verification
Each result is due exactly one clock edge after its inputs are sampled, because there is one register stage from inputs to outputs. The bench drives inputs on the falling edge and lets one rising edge pass. It compares every output on the following falling edge against a model advanced once per step. The sleep flag carries state across steps. The directed sequences therefore set it in one step and check its effect on a blocked interrupt in the next, and an idle step after each taken event confirms that every output holds.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
    parameter int XLEN    = 32;
    parameter int CODE_W  = 12;
    parameter int LVL_W   = 4;
    parameter int DSLOT_W = 2;

    localparam int SR_MD    = 30;
    localparam int SR_RB    = 29;
    localparam int SR_BL    = 28;
    localparam int SR_FD    = 15;
    localparam int SR_IM_LO = 4;

    localparam logic [XLEN-1:0] RESET_PC = XLEN'(32'hA000_0000);
    localparam logic [XLEN-1:0] ENTRY_SR_SET =
        (XLEN'(1) << SR_MD) | (XLEN'(1) << SR_RB) | (XLEN'(1) << SR_BL);
    localparam logic [XLEN-1:0] INSN_BYTES  = XLEN'(2);
    localparam logic [XLEN-1:0] OFS_GENERAL = XLEN'(32'h100);
    localparam logic [XLEN-1:0] OFS_MISS    = XLEN'(32'h400);
    localparam logic [XLEN-1:0] OFS_IRQ     = XLEN'(32'h600);

    localparam logic [CODE_W-1:0] CODE_POWER   = CODE_W'(12'h000);
    localparam logic [CODE_W-1:0] CODE_MANUAL  = CODE_W'(12'h020);
    localparam logic [CODE_W-1:0] CODE_MULTI   = CODE_W'(12'h140);
    localparam logic [CODE_W-1:0] CODE_MISS_RD = CODE_W'(12'h040);
    localparam logic [CODE_W-1:0] CODE_MISS_WR = CODE_W'(12'h060);
    localparam logic [CODE_W-1:0] CODE_TRAP    = CODE_W'(12'h160);
    localparam logic [CODE_W-1:0] CODE_NOBLOCK = CODE_W'(12'h1E0);

    typedef struct packed {
        logic [XLEN-1:0]   sr;
        logic [XLEN-1:0]   ssr;
        logic [XLEN-1:0]   spc;
        logic [XLEN-1:0]   sgr;
        logic [XLEN-1:0]   pc;
        logic [CODE_W-1:0] expevt;
        logic [CODE_W-1:0] intevt;
        logic              sleep;
        logic              dslot_clr;
        logic              taken;
    } entry_state_t;
endpackage

// File: rtl/exc_select.sv
module exc_select
    import exc_entry_pkg::*;
(
    input  logic              exc_valid_i,
    input  logic [CODE_W-1:0] exc_code_i,
    input  logic              irq_req_i,
    input  logic [LVL_W-1:0]  irq_prio_i,
    input  logic [LVL_W-1:0]  imask_i,
    input  logic              blocked_i,
    input  logic              sleeping_i,
    output logic              take_exc_o,
    output logic              take_irq_o,
    output logic [CODE_W-1:0] exc_code_o
);
    always_comb begin
        take_exc_o = exc_valid_i;
        // blocked state turns every exception but one into a reset
        if (blocked_i && (exc_code_i != CODE_NOBLOCK)) begin
            exc_code_o = CODE_POWER;
        end else begin
            exc_code_o = exc_code_i;
        end
        take_irq_o = !exc_valid_i && irq_req_i
                     && (!blocked_i || sleeping_i)
                     && (irq_prio_i > imask_i);
    end
endmodule

// File: rtl/exc_target.sv
module exc_target
    import exc_entry_pkg::*;
(
    input  logic              take_exc_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [XLEN-1:0]   vbr_i,
    input  logic              in_slot_i,
    output logic              reset_class_o,
    output logic [XLEN-1:0]   new_pc_o,
    output logic [XLEN-1:0]   new_spc_o
);
    logic is_miss;
    logic is_trap;

    always_comb begin
        reset_class_o = take_exc_i && ((code_i == CODE_POWER) ||
                                       (code_i == CODE_MANUAL) ||
                                       (code_i == CODE_MULTI));
        is_miss = (code_i == CODE_MISS_RD) || (code_i == CODE_MISS_WR);
        is_trap = take_exc_i && (code_i == CODE_TRAP);

        new_spc_o = pc_i;
        if (in_slot_i) begin
            new_spc_o = new_spc_o - INSN_BYTES;
        end
        if (is_trap) begin
            new_spc_o = new_spc_o + INSN_BYTES;
        end

        if (!take_exc_i) begin
            new_pc_o = vbr_i + OFS_IRQ;
        end else if (reset_class_o) begin
            new_pc_o = RESET_PC;
        end else if (is_miss) begin
            new_pc_o = vbr_i + OFS_MISS;
        end else begin
            new_pc_o = vbr_i + OFS_GENERAL;
        end
    end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               exc_valid_i,
    input  logic [CODE_W-1:0]  exc_code_i,
    input  logic               irq_req_i,
    input  logic [LVL_W-1:0]   irq_prio_i,
    input  logic [CODE_W-1:0]  irq_code_i,
    input  logic [XLEN-1:0]    sr_i,
    input  logic [XLEN-1:0]    pc_i,
    input  logic [XLEN-1:0]    r15_i,
    input  logic [XLEN-1:0]    vbr_i,
    input  logic [DSLOT_W-1:0] dslot_i,
    input  logic               sleep_enter_i,
    output logic [XLEN-1:0]    sr_o,
    output logic [XLEN-1:0]    ssr_o,
    output logic [XLEN-1:0]    spc_o,
    output logic [XLEN-1:0]    sgr_o,
    output logic [CODE_W-1:0]  expevt_o,
    output logic [CODE_W-1:0]  intevt_o,
    output logic [XLEN-1:0]    pc_o,
    output logic               sleep_o,
    output logic               dslot_clr_o,
    output logic               taken_o
);
    entry_state_t st_d, st_q;

    logic              take_exc, take_irq, reset_class;
    logic [CODE_W-1:0] eff_code;
    logic [XLEN-1:0]   tgt_pc, tgt_spc;

    exc_select u_select (
        .exc_valid_i (exc_valid_i),
        .exc_code_i  (exc_code_i),
        .irq_req_i   (irq_req_i),
        .irq_prio_i  (irq_prio_i),
        .imask_i     (sr_i[SR_IM_LO +: LVL_W]),
        .blocked_i   (sr_i[SR_BL]),
        .sleeping_i  (st_q.sleep),
        .take_exc_o  (take_exc),
        .take_irq_o  (take_irq),
        .exc_code_o  (eff_code)
    );

    exc_target u_target (
        .take_exc_i    (take_exc),
        .code_i        (eff_code),
        .pc_i          (pc_i),
        .vbr_i         (vbr_i),
        .in_slot_i     (|dslot_i),
        .reset_class_o (reset_class),
        .new_pc_o      (tgt_pc),
        .new_spc_o     (tgt_spc)
    );

    always_comb begin
        st_d           = st_q;
        st_d.taken     = 1'b0;
        st_d.dslot_clr = 1'b0;
        st_d.sleep     = st_q.sleep | sleep_enter_i;
        if (take_exc || take_irq) begin
            st_d.taken     = 1'b1;
            st_d.sleep     = 1'b0;
            st_d.dslot_clr = |dslot_i;
            st_d.ssr       = sr_i;
            st_d.sgr       = r15_i;
            st_d.spc       = tgt_spc;
            st_d.pc        = tgt_pc;
            st_d.sr        = sr_i | ENTRY_SR_SET;
            if (reset_class) begin
                st_d.sr[SR_FD]               = 1'b0;
                st_d.sr[SR_IM_LO +: LVL_W]   = '1;
            end
            if (take_exc) begin
                st_d.expevt = eff_code;
            end else begin
                st_d.intevt = irq_code_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.pc <= RESET_PC;
            st_q.sr <= ENTRY_SR_SET;
        end else begin
            st_q <= st_d;
        end
    end

    assign sr_o        = st_q.sr;
    assign ssr_o       = st_q.ssr;
    assign spc_o       = st_q.spc;
    assign sgr_o       = st_q.sgr;
    assign expevt_o    = st_q.expevt;
    assign intevt_o    = st_q.intevt;
    assign pc_o        = st_q.pc;
    assign sleep_o     = st_q.sleep;
    assign dslot_clr_o = st_q.dslot_clr;
    assign taken_o     = st_q.taken;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
    import exc_entry_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               exc_valid_i,
    input logic [CODE_W-1:0]  exc_code_i,
    input logic               irq_req_i,
    input logic [LVL_W-1:0]   irq_prio_i,
    input logic [XLEN-1:0]    sr_i,
    input logic [XLEN-1:0]    sr_o,
    input logic [XLEN-1:0]    pc_o,
    input logic [CODE_W-1:0]  expevt_o,
    input logic [CODE_W-1:0]  intevt_o,
    input logic               sleep_o,
    input logic               taken_o
);
    AST_ENTRY_BITS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> (sr_o[SR_MD] && sr_o[SR_RB] && sr_o[SR_BL])); // R5

    AST_IDLE_HOLDS_PC: assert property (@(posedge clk) disable iff (!rst_n)
        !taken_o |-> $stable(pc_o)); // R10

    AST_EXC_OVER_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        $past(exc_valid_i) |-> (taken_o && $stable(intevt_o))); // R1

    AST_SLEEP_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> !sleep_o); // R3

    AST_MASKED_IRQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!exc_valid_i && irq_req_i && (irq_prio_i <= sr_i[SR_IM_LO +: LVL_W]))
        |-> !taken_o); // R4

    AST_BLOCKED_PROMOTED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(exc_valid_i && sr_i[SR_BL] && (exc_code_i != CODE_NOBLOCK))
        |-> (expevt_o == CODE_POWER)); // R2

    AST_RESET_CLASS_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(exc_valid_i) && (expevt_o == CODE_POWER || expevt_o == CODE_MANUAL
                                || expevt_o == CODE_MULTI))
        |-> (pc_o == RESET_PC && sr_o[SR_IM_LO +: LVL_W] == '1 && !sr_o[SR_FD])); // R7
endmodule

bind exc_entry_seq exc_entry_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .exc_valid_i (exc_valid_i),
    .exc_code_i  (exc_code_i),
    .irq_req_i   (irq_req_i),
    .irq_prio_i  (irq_prio_i),
    .sr_i        (sr_i),
    .sr_o        (sr_o),
    .pc_o        (pc_o),
    .expevt_o    (expevt_o),
    .intevt_o    (intevt_o),
    .sleep_o     (sleep_o),
    .taken_o     (taken_o)
);

// File: tb/exc_entry_seq_bench.sv
module exc_entry_seq_bench;
    import exc_entry_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 3000;
    localparam int WATCHDOG   = 200000;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               exc_valid_i = 1'b0;
    logic [CODE_W-1:0]  exc_code_i = '0;
    logic               irq_req_i = 1'b0;
    logic [LVL_W-1:0]   irq_prio_i = '0;
    logic [CODE_W-1:0]  irq_code_i = '0;
    logic [XLEN-1:0]    sr_i = '0;
    logic [XLEN-1:0]    pc_i = '0;
    logic [XLEN-1:0]    r15_i = '0;
    logic [XLEN-1:0]    vbr_i = '0;
    logic [DSLOT_W-1:0] dslot_i = '0;
    logic               sleep_enter_i = 1'b0;
    logic [XLEN-1:0]    sr_o, ssr_o, spc_o, sgr_o, pc_o;
    logic [CODE_W-1:0]  expevt_o, intevt_o;
    logic               sleep_o, dslot_clr_o, taken_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_sr, m_ssr, m_spc, m_sgr, m_pc;
    logic [11:0] m_expevt, m_intevt;
    logic        m_sleep, m_dclr, m_taken;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_entry_seq u_exc_entry_seq (
        .clk(clk), .rst_n(rst_n), .exc_valid_i(exc_valid_i), .exc_code_i(exc_code_i),
        .irq_req_i(irq_req_i), .irq_prio_i(irq_prio_i), .irq_code_i(irq_code_i),
        .sr_i(sr_i), .pc_i(pc_i), .r15_i(r15_i), .vbr_i(vbr_i), .dslot_i(dslot_i),
        .sleep_enter_i(sleep_enter_i), .sr_o(sr_o), .ssr_o(ssr_o), .spc_o(spc_o),
        .sgr_o(sgr_o), .expevt_o(expevt_o), .intevt_o(intevt_o), .pc_o(pc_o),
        .sleep_o(sleep_o), .dslot_clr_o(dslot_clr_o), .taken_o(taken_o)
    );

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        check(tag, "taken", {31'b0, taken_o}, {31'b0, m_taken});
        check(tag, "sr", sr_o, m_sr);
        check(tag, "ssr", ssr_o, m_ssr);
        check(tag, "spc", spc_o, m_spc);
        check(tag, "sgr", sgr_o, m_sgr);
        check(tag, "pc", pc_o, m_pc);
        check(tag, "expevt", {20'b0, expevt_o}, {20'b0, m_expevt});
        check(tag, "intevt", {20'b0, intevt_o}, {20'b0, m_intevt});
        check(tag, "sleep", {31'b0, sleep_o}, {31'b0, m_sleep});
        check(tag, "dslot_clr", {31'b0, dslot_clr_o}, {31'b0, m_dclr});
    endtask

    // expected next state, from the requirements
    task automatic model_step();
        logic bl, irq;
        logic [11:0] code;
        bl  = sr_i[28];
        irq = !exc_valid_i && irq_req_i && (irq_prio_i > sr_i[7:4]) && (!bl || m_sleep);
        m_taken = exc_valid_i || irq;
        m_dclr  = 1'b0;
        if (!m_taken) begin
            m_sleep = m_sleep | sleep_enter_i;
            return;
        end
        m_sleep = 1'b0;
        m_dclr  = (dslot_i != 2'b00);
        m_ssr   = sr_i;
        m_sgr   = r15_i;
        m_sr    = sr_i | 32'h7000_0000;
        m_spc   = (dslot_i != 2'b00) ? pc_i - 32'd2 : pc_i;
        if (irq) begin
            m_intevt = irq_code_i;
            m_pc     = vbr_i + 32'h600;
        end else begin
            code = (bl && exc_code_i != 12'h1E0) ? 12'h000 : exc_code_i;
            m_expevt = code;
            case (code)
                12'h000, 12'h020, 12'h140: begin
                    m_sr[15]  = 1'b0;
                    m_sr[7:4] = 4'hF;
                    m_pc      = 32'hA000_0000;
                end
                12'h040, 12'h060: m_pc = vbr_i + 32'h400;
                12'h160: begin
                    m_spc = m_spc + 32'd2;
                    m_pc  = vbr_i + 32'h100;
                end
                default: m_pc = vbr_i + 32'h100;
            endcase
        end
    endtask

    task automatic step(string tag, logic ev, logic [11:0] code, logic irq,
                        logic [3:0] prio, logic [11:0] icode, logic [31:0] sr,
                        logic [31:0] pc, logic [31:0] r15, logic [31:0] vbr,
                        logic [1:0] ds, logic slp);
        exc_valid_i = ev;  exc_code_i = code;  irq_req_i = irq;
        irq_prio_i = prio; irq_code_i = icode; sr_i = sr;
        pc_i = pc; r15_i = r15; vbr_i = vbr; dslot_i = ds; sleep_enter_i = slp;
        model_step();
        @(posedge clk);
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic idle(string tag);
        step(tag, 1'b0, 12'h0, 1'b0, 4'h0, 12'h0, 32'h0, 32'h0, 32'h0, 32'h0, 2'b00, 1'b0);
    endtask

    function automatic logic [11:0] pick_code(int unsigned k);
        case (k % 12)
            0: return 12'h000;  1: return 12'h020;  2: return 12'h040;
            3: return 12'h060;  4: return 12'h0A0;  5: return 12'h0C0;
            6: return 12'h0E0;  7: return 12'h100;  8: return 12'h140;
            9: return 12'h160;  10: return 12'h180; default: return 12'h1E0;
        endcase
    endfunction

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        m_sr = 32'h7000_0000; m_pc = 32'hA000_0000;
        m_ssr = 0; m_spc = 0; m_sgr = 0; m_expevt = 0; m_intevt = 0;
        m_sleep = 0; m_dclr = 0; m_taken = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state, no event in the first cycle
        idle("R11");

        // R1: exception and an eligible interrupt together
        step("R1", 1'b1, 12'h180, 1'b1, 4'hF, 12'h3C0, 32'h0000_0010, 32'h1000_0100,
             32'h8C00_0FF0, 32'h8C00_0000, 2'b00, 1'b0);
        idle("R10");
        // R2: blocked exception becomes reset; 0x1E0 passes through
        step("R2", 1'b1, 12'h0A0, 1'b0, 4'h0, 12'h0, 32'h1000_0000, 32'h2000_0000,
             32'h1234, 32'h8C00_0000, 2'b00, 1'b0);
        step("R2", 1'b1, 12'h1E0, 1'b0, 4'h0, 12'h0, 32'h1000_0000, 32'h2000_0040,
             32'h1234, 32'h8C00_0000, 2'b00, 1'b0);
        // R3: blocked interrupt while awake is ignored; then sleep, then accepted
        step("R3", 1'b0, 12'h0, 1'b1, 4'hF, 12'h200, 32'h1000_0000, 32'h3000_0000,
             32'h0, 32'h8C00_0000, 2'b00, 1'b0);
        step("R3", 1'b0, 12'h0, 1'b0, 4'h0, 12'h0, 32'h0, 32'h0, 32'h0, 32'h0, 2'b00, 1'b1);
        step("R3", 1'b0, 12'h0, 1'b1, 4'hF, 12'h220, 32'h1000_0000, 32'h3000_0002,
             32'h77, 32'h8C00_0000, 2'b00, 1'b0);
        // R4: priority equal to mask ignored, one above accepted
        step("R4", 1'b0, 12'h0, 1'b1, 4'h5, 12'h240, 32'h0000_0050, 32'h4000_0000,
             32'h0, 32'h8C00_0000, 2'b00, 1'b0);
        step("R9", 1'b0, 12'h0, 1'b1, 4'h6, 12'h260, 32'h0000_0050, 32'h4000_0000,
             32'h55, 32'h8C00_1000, 2'b00, 1'b0);
        // R6: delay slot rewinds; trap in a delay slot nets to pc
        step("R6", 1'b1, 12'h180, 1'b0, 4'h0, 12'h0, 32'h0, 32'h5000_0010,
             32'h9, 32'h8C00_0000, 2'b01, 1'b0);
        step("R6", 1'b1, 12'h160, 1'b0, 4'h0, 12'h0, 32'h0, 32'h5000_0020,
             32'h9, 32'h8C00_0000, 2'b10, 1'b0);
        // R7: reset-class code clears FD, sets mask
        step("R7", 1'b1, 12'h020, 1'b0, 4'h0, 12'h0, 32'h0000_8030, 32'h6000_0000,
             32'hA, 32'h8C00_0000, 2'b00, 1'b0);
        step("R7", 1'b1, 12'h140, 1'b0, 4'h0, 12'h0, 32'h4000_8000, 32'h6000_0004,
             32'hA, 32'h8C00_0000, 2'b00, 1'b0);
        // R8: miss vectors and trap advance
        step("R8", 1'b1, 12'h040, 1'b0, 4'h0, 12'h0, 32'h0, 32'h7000_0000,
             32'h1, 32'h8C00_2000, 2'b00, 1'b0);
        step("R8", 1'b1, 12'h060, 1'b0, 4'h0, 12'h0, 32'h0, 32'h7000_0010,
             32'h1, 32'h8C00_2000, 2'b00, 1'b0);
        step("R8", 1'b1, 12'h160, 1'b0, 4'h0, 12'h0, 32'h0, 32'h7000_0020,
             32'h1, 32'h8C00_2000, 2'b00, 1'b0);
        step("R5", 1'b1, 12'h0E0, 1'b0, 4'h0, 12'h0, 32'h0000_00F3, 32'h7000_0030,
             32'hDEAD_BEE0, 32'h8C00_2000, 2'b00, 1'b0);
        idle("R10");

        for (int n = 0; n < N_RANDOM; n++) begin
            logic ev, rq, slp;
            logic [11:0] code;
            logic [31:0] sr;
            logic [1:0] ds;
            string tag;
            ev   = ($urandom % 3) == 0;
            rq   = ($urandom % 2) == 0;
            slp  = ($urandom % 8) == 0;
            code = pick_code($urandom);
            sr   = $urandom;
            sr[28] = ($urandom % 4) == 0;
            ds   = (($urandom % 4) == 0) ? 2'($urandom % 3 + 1) : 2'b00;
            if (ev && sr[28] && code != 12'h1E0) tag = "R2";
            else if (ev) tag = "R8";
            else if (rq) tag = "R4";
            else tag = "R10";
            step(tag, ev, code, rq, 4'($urandom), 12'($urandom), sr,
                 $urandom & 32'hFFFF_FFFE, $urandom, $urandom & 32'hFFFF_F000, ds, slp);
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule